// File: doc/BRIEF.md
# PLL Feedback-Divider Ramp Sequencer

This block changes the feedback multiplier N of a PLL that is already running, without dropping lock. It uses the PLL's built-in dynamic ramp. A start pulse carries in the requested N together with the coefficient word currently held by the PLL. If N really changes, the sequencer raises slowdown mode, lets it settle, and writes back the coefficient word with only the N field replaced. After a further settle time it enables the dynamic ramp. It then waits for the PLL's ramp-complete flag, but only for a bounded time. Whatever the outcome, it releases both controls before it signals completion.

All waits are measured in microseconds. A prescaler turns the system clock into a microsecond count, and a parameter sets the number of clock cycles per microsecond. The ramp-complete flag comes from the PLL clock domain, so it is resynchronised inside the block. The block also decodes the reference frequency into the two ramp step values the PLL needs, and flags a reference frequency it does not support.

Top module: `ndiv_ramp_seq`

## Requirements
- R1: After reset, slowdown, rampEn, coeffWr, done and timeoutErr are all low.
- R2: When start is sampled with reqN equal to the N field of curCoeff, done pulses high in the very next cycle with timeoutErr low, and slowdown, rampEn and coeffWr stay low throughout.
- R3: When N differs, slowdown rises in the cycle after start and stays high, with no write, for US_CYCLES+1 cycles (1 µs) before the write.
- R4: The write is a single-cycle coeffWr pulse. Its coeffData keeps M in bits [7:0] and PL in bits [21:16] from curCoeff and puts reqN in bits [15:8].
- R5: After the write, slowdown stays high alone for US_CYCLES+1 cycles (1 µs). Then rampEn rises while slowdown is still high.
- R6: The ramp-complete input is passed through two flops. When it is seen during the ramp wait, the sequence ends with timeoutErr low.
- R7: If ramp-complete never arrives, the wait ends after TIMEOUT_US µs (TIMEOUT_US·US_CYCLES+1 cycles of rampEn), and timeoutErr is set. timeoutErr holds until the next start.
- R8: slowdown and rampEn fall in the same cycle. At least one cycle with both low passes before the one-cycle done pulse.
- R9: For refKhz of 12000, 12800 or 13000 the step values are 0x2B/0x0B. For 19200 they are 0x12/0x08, and for 38400 they are 0x04/0x05. Any other value gives cfgErr high and both step values 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| reqN | input | N_W | Requested feedback multiplier |
| curCoeff | input | M_W+N_W+PL_W | Coefficient word now in the PLL (M low, N middle, PL high) |
| rampDoneAsync | input | 1 | Ramp-complete flag from the PLL domain |
| refKhz | input | REF_W | Reference frequency in kHz |
| slowdown | output | 1 | Slowdown-mode control |
| rampEn | output | 1 | Dynamic-ramp enable |
| coeffWr | output | 1 | Coefficient write strobe |
| coeffData | output | M_W+N_W+PL_W | Coefficient word to write |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Ramp wait expired in the last sequence |
| stepA | output | 8 | First ramp step value |
| stepB | output | 8 | Second ramp step value |
| cfgErr | output | 1 | Unsupported reference frequency |

## Verification
The hardest path to reach is the timeout. It needs a ramp-complete flag that never arrives, and a wait of a full TIMEOUT_US microseconds. The bench shortens the microsecond to four cycles and uses a PLL model that can withhold its answer, so the 500 µs limit becomes 2001 ramp cycles, which the bench counts exactly. The run after the timeout answers normally, which shows that the error flag clears on the next start.

// File: rtl/rampseq_pkg.sv
package rampseq_pkg;
  typedef struct packed {
    logic capture;
    logic clrTimer;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SLOW, S_WRITE, S_SETTLE, S_RAMP, S_EXIT, S_DONE
  } seqState_t;
endpackage

// File: rtl/ndiv_ramp_dp.sv
module ndiv_ramp_dp
  import rampseq_pkg::*;
#(
  parameter int M_W        = 8,
  parameter int N_W        = 8,
  parameter int PL_W       = 6,
  parameter int US_CYCLES  = 1000,
  parameter int TIMEOUT_US = 500,
  parameter int REF_W      = 16,
  localparam int COEFF_W   = M_W + N_W + PL_W,
  localparam int PL_LSB    = M_W + N_W,
  localparam int PRE_W     = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1,
  localparam int US_W      = $clog2(TIMEOUT_US + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [N_W-1:0]     reqN,
  input  logic [COEFF_W-1:0] curCoeff,
  input  logic               rampDoneAsync,
  input  logic [REF_W-1:0]   refKhz,
  output logic               nMatch,
  output logic               syncDone,
  output logic [US_W-1:0]    usCount,
  output logic [COEFF_W-1:0] coeffData,
  output logic [7:0]         stepA,
  output logic [7:0]         stepB,
  output logic               cfgErr
);
  logic [PRE_W-1:0] preCount;
  logic             syncMeta;

  assign nMatch = (reqN == curCoeff[PL_LSB-1:M_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncDone <= 1'b0;
    end else begin
      syncMeta <= rampDoneAsync;
      syncDone <= syncMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCount <= '0;
      usCount  <= '0;
    end else if (strobe.clrTimer) begin
      preCount <= '0;
      usCount  <= '0;
    end else if (preCount == PRE_W'(US_CYCLES - 1)) begin
      preCount <= '0;
      if (usCount != US_W'(TIMEOUT_US)) usCount <= usCount + 1'b1;
    end else begin
      preCount <= preCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) coeffData <= '0;
    else if (strobe.capture)
      coeffData <= {curCoeff[COEFF_W-1:PL_LSB], reqN, curCoeff[M_W-1:0]};
  end

  always_comb begin
    cfgErr = 1'b0;
    unique case (refKhz)
      REF_W'(12000), REF_W'(12800), REF_W'(13000): begin stepA = 8'h2B; stepB = 8'h0B; end
      REF_W'(19200): begin stepA = 8'h12; stepB = 8'h08; end
      REF_W'(38400): begin stepA = 8'h04; stepB = 8'h05; end
      default: begin stepA = 8'h00; stepB = 8'h00; cfgErr = 1'b1; end
    endcase
  end

  // R6: a rising synchronised flag was present at the input two cycles earlier
  p_sync_two_flop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncDone) |-> $past(rampDoneAsync, 2));
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl
  import rampseq_pkg::*;
#(
  parameter int TIMEOUT_US = 500,
  localparam int US_W      = $clog2(TIMEOUT_US + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            nMatch,
  input  logic            syncDone,
  input  logic [US_W-1:0] usCount,
  output seqStrobe_t      strobe,
  output logic            slowdown,
  output logic            rampEn,
  output logic            coeffWr,
  output logic            done,
  output logic            timeoutErr
);
  seqState_t state, nextState;
  logic setErr, clrErr;

  always_comb begin
    nextState = state;
    strobe    = '0;
    setErr    = 1'b0;
    clrErr    = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.capture  = 1'b1;
        strobe.clrTimer = 1'b1;
        clrErr          = 1'b1;
        nextState       = nMatch ? S_DONE : S_SLOW;
      end
      S_SLOW:   if (usCount >= US_W'(1)) nextState = S_WRITE;
      S_WRITE: begin
        strobe.clrTimer = 1'b1;
        nextState       = S_SETTLE;
      end
      S_SETTLE: if (usCount >= US_W'(1)) begin
        strobe.clrTimer = 1'b1;
        nextState       = S_RAMP;
      end
      S_RAMP: begin
        if (syncDone) nextState = S_EXIT;
        else if (usCount >= US_W'(TIMEOUT_US)) begin
          setErr    = 1'b1;
          nextState = S_EXIT;
        end
      end
      S_EXIT:  nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      timeoutErr <= 1'b0;
    end else begin
      state <= nextState;
      if (clrErr) timeoutErr <= 1'b0;
      else if (setErr) timeoutErr <= 1'b1;
    end
  end

  assign slowdown = (state == S_SLOW) || (state == S_WRITE) ||
                    (state == S_SETTLE) || (state == S_RAMP);
  assign rampEn   = (state == S_RAMP);
  assign coeffWr  = (state == S_WRITE);
  assign done     = (state == S_DONE);

  // R8: leaving slowdown drops the ramp enable in the same cycle
  p_joint_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slowdown) |-> $fell(rampEn));
  // R3: a write is always preceded by slowdown
  p_write_in_slowdown_r3: assert property (@(posedge clk) disable iff (!rstN)
    coeffWr |-> $past(slowdown));
  // R5: the ramp enable never follows the write directly
  p_settle_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    coeffWr |=> !rampEn);
  // R8: done is reported with both controls released
  p_done_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!slowdown && !rampEn && $past(!rampEn)));
  // R7: the error appears only on the way to done, out of the ramp wait
  p_err_from_ramp_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(rampEn));
endmodule

// File: rtl/ndiv_ramp_seq.sv
module ndiv_ramp_seq
  import rampseq_pkg::*;
#(
  parameter int M_W        = 8,
  parameter int N_W        = 8,
  parameter int PL_W       = 6,
  parameter int US_CYCLES  = 1000,
  parameter int TIMEOUT_US = 500,
  parameter int REF_W      = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [N_W-1:0]            reqN,
  input  logic [M_W+N_W+PL_W-1:0]   curCoeff,
  input  logic                      rampDoneAsync,
  input  logic [REF_W-1:0]          refKhz,
  output logic                      slowdown,
  output logic                      rampEn,
  output logic                      coeffWr,
  output logic [M_W+N_W+PL_W-1:0]   coeffData,
  output logic                      done,
  output logic                      timeoutErr,
  output logic [7:0]                stepA,
  output logic [7:0]                stepB,
  output logic                      cfgErr
);
  localparam int US_W = $clog2(TIMEOUT_US + 1);

  seqStrobe_t      strobe;
  logic            nMatch;
  logic            syncDone;
  logic [US_W-1:0] usCount;

  ndiv_ramp_ctrl #(.TIMEOUT_US(TIMEOUT_US)) uCtrl (
    .clk, .rstN, .start, .nMatch, .syncDone, .usCount, .strobe,
    .slowdown, .rampEn, .coeffWr, .done, .timeoutErr
  );

  ndiv_ramp_dp #(
    .M_W(M_W), .N_W(N_W), .PL_W(PL_W), .US_CYCLES(US_CYCLES),
    .TIMEOUT_US(TIMEOUT_US), .REF_W(REF_W)
  ) uDp (
    .clk, .rstN, .strobe, .reqN, .curCoeff, .rampDoneAsync, .refKhz,
    .nMatch, .syncDone, .usCount, .coeffData, .stepA, .stepB, .cfgErr
  );
endmodule

// File: tb/ndiv_ramp_seq_test.sv
module ndiv_ramp_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int US = 4;
  localparam int TMO = 500;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, rampDoneAsync;
  logic [7:0] reqN = '0;
  logic [21:0] curCoeff = '0, coeffData;
  logic [15:0] refKhz = '0;
  logic slowdown, rampEn, coeffWr, done, timeoutErr, cfgErr;
  logic [7:0] stepA, stepB;

  int total = 0, fails = 0, cycles = 0;
  int respDelay = -1, rampAge = 0;
  int slowCnt, wrCnt, settleCnt, rampCnt, exitCnt;
  bit dropTogether, doneClean;
  logic [21:0] wrData;

  // {refKhz, stepA, stepB, cfgErr}
  localparam logic [32:0] VEC [8] = '{
    {16'd12000, 8'h2B, 8'h0B, 1'b0}, {16'd12800, 8'h2B, 8'h0B, 1'b0},
    {16'd13000, 8'h2B, 8'h0B, 1'b0}, {16'd19200, 8'h12, 8'h08, 1'b0},
    {16'd38400, 8'h04, 8'h05, 1'b0}, {16'd0,     8'h00, 8'h00, 1'b1},
    {16'd24000, 8'h00, 8'h00, 1'b1}, {16'd12001, 8'h00, 8'h00, 1'b1}};

  ndiv_ramp_seq #(.US_CYCLES(US), .TIMEOUT_US(TMO)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // PLL model: answers ramp-complete respDelay cycles after rampEn, or never
  always @(posedge clk) begin
    if (!rampEn) begin
      rampAge <= 0;
      rampDoneAsync <= 1'b0;
    end else begin
      rampAge <= rampAge + 1;
      if (respDelay >= 0 && rampAge >= respDelay) rampDoneAsync <= 1'b1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runSeq(input logic [7:0] n, input logic [21:0] cur, input int delay);
    bit prevSlow = 0, prevRamp = 0, sawRamp = 0;
    int guard = 0;
    slowCnt = 0; wrCnt = 0; settleCnt = 0; rampCnt = 0; exitCnt = 0;
    dropTogether = 1; wrData = '0;
    respDelay = delay;
    @(negedge clk); reqN = n; curCoeff = cur; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && guard < 5000) begin
      if (prevSlow && !slowdown) dropTogether = dropTogether && prevRamp && !rampEn;
      if (prevRamp && !rampEn && slowdown) dropTogether = 0;
      if (coeffWr) begin wrCnt++; wrData = coeffData; end
      else if (rampEn) begin rampCnt++; sawRamp = 1; end
      else if (slowdown) begin if (wrCnt == 0) slowCnt++; else settleCnt++; end
      else if (sawRamp) exitCnt++;
      prevSlow = slowdown; prevRamp = rampEn;
      guard++;
      @(negedge clk);
    end
    doneClean = done && !slowdown && !rampEn;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({slowdown, rampEn, coeffWr, done, timeoutErr} == 5'b0, "R1 reset outputs",
        {slowdown, rampEn, coeffWr, done, timeoutErr}, 0);
    rstN = 1'b1;

    // R9: reference-frequency decode table
    foreach (VEC[i]) begin
      @(negedge clk); refKhz = VEC[i][32:17];
      #1;
      chk({stepA, stepB, cfgErr} == VEC[i][16:0], "R9 step decode",
          {stepA, stepB, cfgErr}, VEC[i][16:0]);
    end

    // R2: equal N finishes at once without touching controls
    runSeq(8'd40, {6'd3, 8'd40, 8'd2}, 3);
    chk(slowCnt + wrCnt + rampCnt + settleCnt == 0, "R2 no controls", slowCnt + wrCnt + rampCnt, 0);
    chk(done && !timeoutErr, "R2 immediate done", {done, timeoutErr}, 2'b10);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);

    // R3..R8: successful ramp
    runSeq(8'd60, {6'd3, 8'd40, 8'd2}, 3);
    chk(slowCnt == US + 1, "R3 slowdown before write", slowCnt, US + 1);
    chk(wrCnt == 1, "R4 single write", wrCnt, 1);
    chk(wrData == {6'd3, 8'd60, 8'd2}, "R4 write data", wrData, {6'd3, 8'd60, 8'd2});
    chk(settleCnt == US + 1, "R5 settle after write", settleCnt, US + 1);
    chk(rampCnt >= 3 && rampCnt < TMO * US, "R6 ramp length", rampCnt, 3);
    chk(!timeoutErr, "R6 no error", timeoutErr, 0);
    chk(dropTogether, "R8 joint release", dropTogether, 1);
    chk(exitCnt >= 1 && doneClean, "R8 gap before done", exitCnt, 1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);

    // Another pattern: extreme fields
    runSeq(8'd7, {6'h2A, 8'd200, 8'd255}, 10);
    chk(wrData == {6'h2A, 8'd7, 8'd255}, "R4 write data 2", wrData, {6'h2A, 8'd7, 8'd255});
    chk(slowCnt == US + 1 && settleCnt == US + 1, "R3 R5 delays 2", slowCnt, US + 1);
    chk(!timeoutErr, "R6 no error 2", timeoutErr, 0);

    // R7: ramp-complete never arrives
    runSeq(8'd90, {6'd1, 8'd20, 8'd1}, -1);
    chk(rampCnt == TMO * US + 1, "R7 timeout length", rampCnt, TMO * US + 1);
    chk(timeoutErr, "R7 error set", timeoutErr, 1);
    chk(dropTogether && exitCnt >= 1 && doneClean, "R8 release after timeout", dropTogether, 1);
    repeat (3) @(negedge clk);
    chk(timeoutErr, "R7 error held", timeoutErr, 1);

    // R7: next start clears the error
    runSeq(8'd20, {6'd1, 8'd90, 8'd1}, 0);
    chk(!timeoutErr, "R7 error cleared", timeoutErr, 0);
    chk(wrData == {6'd1, 8'd20, 8'd1}, "R4 write data 3", wrData, {6'd1, 8'd20, 8'd1});

    summary();
  end
endmodule